// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the combinational hazard logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose branches are compared for equality in the decode stage. It looks at the source register numbers of the instructions in decode and execute. It also looks at the destination numbers, write enables and load flags of the instructions in execute, memory and writeback.

From these it produces four groups of controls:
- operand bypass selects for the two execute-stage ALU inputs;
- bypass selects for the two inputs of the decode-stage branch comparator;
- hold enables for the program counter and the fetch/decode register;
- clear controls for the fetch/decode and decode/execute registers.

The surrounding datapath owns the pipeline registers, the multiplexers and the comparator. It feeds the comparator result back through `br_taken_i` and applies the controls at the next clock edge.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute operand select (`exa_sel_o` for rs, `exb_sel_o` for rt) is 2'b10 when the memory stage has its write enable set and writes a nonzero register equal to that operand. This holds even when writeback matches as well.
- R2: An execute operand select is 2'b01 when the memory stage does not qualify under R1 and the writeback stage has its write enable set and writes a nonzero register equal to that operand.
- R3: Otherwise an execute operand select is 2'b00. Register 0 or a cleared write enable never yields a bypass, and the code 2'b11 never appears.
- R4: A load in execute (`ex_load_i` and `ex_wen_i` set, nonzero `ex_wreg_i`) whose destination equals decode rs or rt raises `pc_hold_o`, `ifid_hold_o` and `idex_clear_o`. This applies to any instruction in decode.
- R5: A branch in decode whose rs or rt equals the nonzero destination of a write-enabled instruction in execute stalls. The stall raises the same three outputs as R4.
- R6: A branch in decode whose rs or rt equals the nonzero destination of a write-enabled load in memory stalls. A write-enabled non-load in memory causes no stall.
- R7: A decode comparator select (`bra_sel_o` for rs, `brb_sel_o` for rt) is 1 exactly when the memory stage has its write enable set and writes a nonzero register equal to that operand.
- R8: `ifid_clear_o` is 1 when a branch in decode is taken and no stall is active. A stall suppresses it.
- R9: When decode holds no branch, `br_taken_i` and the branch stall conditions of R5 and R6 have no effect on any output.
- R10: `idex_clear_o`, `pc_hold_o` and `ifid_hold_o` are always equal. `idex_clear_o` is the OR of the load-use and branch stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | RW | Decode-stage first source register |
| id_rt_i | input | RW | Decode-stage second source register |
| id_branch_i | input | 1 | Decode holds a branch |
| br_taken_i | input | 1 | Decode comparator reports branch taken |
| ex_rs_i | input | RW | Execute-stage first source register |
| ex_rt_i | input | RW | Execute-stage second source register |
| ex_wreg_i | input | RW | Execute-stage destination register |
| ex_wen_i | input | 1 | Execute-stage register write enable |
| ex_load_i | input | 1 | Execute stage holds a load |
| mem_wreg_i | input | RW | Memory-stage destination register |
| mem_wen_i | input | 1 | Memory-stage register write enable |
| mem_load_i | input | 1 | Memory stage holds a load |
| wb_wreg_i | input | RW | Writeback-stage destination register |
| wb_wen_i | input | 1 | Writeback-stage register write enable |
| exa_sel_o | output | 2 | Execute source A bypass select |
| exb_sel_o | output | 2 | Execute source B bypass select |
| bra_sel_o | output | 1 | Comparator input A takes memory-stage ALU result |
| brb_sel_o | output | 1 | Comparator input B takes memory-stage ALU result |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| ifid_clear_o | output | 1 | Clear the fetch/decode register |
| idex_clear_o | output | 1 | Insert a bubble into decode/execute |

## Verification
Two functions can fall in the same cycle. A taken-branch flush can meet a stall, and a load-use stall can meet a branch stall. The bench provokes the first by setting `br_taken_i` on a branch whose source matches a producer in execute or a load in memory. It provokes the second by putting a load in execute that a branch in decode reads. Directed cases cover both, and a random phase draws register numbers from a narrow range so that such overlaps are frequent. Each cycle the reference model's expected controls are compared with every output, and the flush must stay low whenever any stall is raised.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Execute-stage bypass select encoding.
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } ex_sel_e;

    // Control bundle produced by the top-level combine step.
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_clear;
        logic idex_clear;
    } pipe_ctl_t;

endpackage

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_i,
    input  logic          mem_wen_i,
    input  logic [RW-1:0] mem_wreg_i,
    input  logic          wb_wen_i,
    input  logic [RW-1:0] wb_wreg_i,
    output logic [1:0]    sel_o
);
    import hz_pkg::*;

    logic mem_hit_d;
    logic wb_hit_d;

    always_comb begin
        mem_hit_d = mem_wen_i && (mem_wreg_i != '0) && (mem_wreg_i == src_i);
        wb_hit_d  = wb_wen_i  && (wb_wreg_i  != '0) && (wb_wreg_i  == src_i);
        // Newer (memory-stage) value takes priority over writeback.
        if (mem_hit_d)
            sel_o = SEL_MEM;
        else if (wb_hit_d)
            sel_o = SEL_WB;
        else
            sel_o = SEL_REGFILE;
    end

endmodule

// File: rtl/hz_br_fwd.sv
module hz_br_fwd #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_i,
    input  logic          mem_wen_i,
    input  logic [RW-1:0] mem_wreg_i,
    output logic          sel_o
);

    always_comb begin
        sel_o = mem_wen_i && (mem_wreg_i != '0) && (mem_wreg_i == src_i);
    end

endmodule

// File: rtl/hz_stall.sv
module hz_stall #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs_i,
    input  logic [RW-1:0] id_rt_i,
    input  logic          id_branch_i,
    input  logic [RW-1:0] ex_wreg_i,
    input  logic          ex_wen_i,
    input  logic          ex_load_i,
    input  logic [RW-1:0] mem_wreg_i,
    input  logic          mem_wen_i,
    input  logic          mem_load_i,
    output logic          lu_stall_o,
    output logic          br_stall_o
);

    logic ex_dep_d;
    logic mem_dep_d;

    always_comb begin
        ex_dep_d  = ex_wen_i && (ex_wreg_i != '0) &&
                    ((ex_wreg_i == id_rs_i) || (ex_wreg_i == id_rt_i));
        mem_dep_d = mem_wen_i && (mem_wreg_i != '0) &&
                    ((mem_wreg_i == id_rs_i) || (mem_wreg_i == id_rt_i));

        // Load data appears only after the memory stage.
        lu_stall_o = ex_load_i && ex_dep_d;

        // Comparator sits in decode: an execute producer is never in reach,
        // a load in memory is not in reach either.
        br_stall_o = id_branch_i && (ex_dep_d || (mem_load_i && mem_dep_d));
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_rs_i,
    input  logic [RW-1:0] id_rt_i,
    input  logic          id_branch_i,
    input  logic          br_taken_i,
    input  logic [RW-1:0] ex_rs_i,
    input  logic [RW-1:0] ex_rt_i,
    input  logic [RW-1:0] ex_wreg_i,
    input  logic          ex_wen_i,
    input  logic          ex_load_i,
    input  logic [RW-1:0] mem_wreg_i,
    input  logic          mem_wen_i,
    input  logic          mem_load_i,
    input  logic [RW-1:0] wb_wreg_i,
    input  logic          wb_wen_i,
    output logic [1:0]    exa_sel_o,
    output logic [1:0]    exb_sel_o,
    output logic          bra_sel_o,
    output logic          brb_sel_o,
    output logic          pc_hold_o,
    output logic          ifid_hold_o,
    output logic          ifid_clear_o,
    output logic          idex_clear_o
);
    import hz_pkg::*;

    localparam int NSRC = 2;

    logic [RW-1:0] ex_src  [NSRC];
    logic [RW-1:0] id_src  [NSRC];
    logic [1:0]    ex_sel  [NSRC];
    logic          br_sel  [NSRC];
    logic          lu_stall;
    logic          br_stall;
    pipe_ctl_t     ctl_d;

    always_comb begin
        ex_src[0] = ex_rs_i;
        ex_src[1] = ex_rt_i;
        id_src[0] = id_rs_i;
        id_src[1] = id_rt_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_ex_fwd #(.RW(RW)) u_exf (
            .src_i      (ex_src[g]),
            .mem_wen_i  (mem_wen_i),
            .mem_wreg_i (mem_wreg_i),
            .wb_wen_i   (wb_wen_i),
            .wb_wreg_i  (wb_wreg_i),
            .sel_o      (ex_sel[g])
        );
        hz_br_fwd #(.RW(RW)) u_brf (
            .src_i      (id_src[g]),
            .mem_wen_i  (mem_wen_i),
            .mem_wreg_i (mem_wreg_i),
            .sel_o      (br_sel[g])
        );
    end

    hz_stall #(.RW(RW)) u_stall (
        .id_rs_i     (id_rs_i),
        .id_rt_i     (id_rt_i),
        .id_branch_i (id_branch_i),
        .ex_wreg_i   (ex_wreg_i),
        .ex_wen_i    (ex_wen_i),
        .ex_load_i   (ex_load_i),
        .mem_wreg_i  (mem_wreg_i),
        .mem_wen_i   (mem_wen_i),
        .mem_load_i  (mem_load_i),
        .lu_stall_o  (lu_stall),
        .br_stall_o  (br_stall)
    );

    always_comb begin
        ctl_d            = '0;
        ctl_d.pc_hold    = lu_stall || br_stall;
        ctl_d.ifid_hold  = ctl_d.pc_hold;
        ctl_d.idex_clear = ctl_d.pc_hold;
        // A held decode instruction must not be discarded.
        ctl_d.ifid_clear = id_branch_i && br_taken_i && !ctl_d.pc_hold;
    end

    assign exa_sel_o    = ex_sel[0];
    assign exb_sel_o    = ex_sel[1];
    assign bra_sel_o    = br_sel[0];
    assign brb_sel_o    = br_sel[1];
    assign pc_hold_o    = ctl_d.pc_hold;
    assign ifid_hold_o  = ctl_d.ifid_hold;
    assign ifid_clear_o = ctl_d.ifid_clear;
    assign idex_clear_o = ctl_d.idex_clear;

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
    parameter int RW = 5
) (
    input logic [RW-1:0] id_rs_i,
    input logic [RW-1:0] id_rt_i,
    input logic          id_branch_i,
    input logic          br_taken_i,
    input logic [RW-1:0] ex_rs_i,
    input logic [RW-1:0] ex_wreg_i,
    input logic          ex_wen_i,
    input logic          ex_load_i,
    input logic [RW-1:0] mem_wreg_i,
    input logic          mem_wen_i,
    input logic [RW-1:0] wb_wreg_i,
    input logic          wb_wen_i,
    input logic [1:0]    exa_sel_o,
    input logic [1:0]    exb_sel_o,
    input logic          bra_sel_o,
    input logic          pc_hold_o,
    input logic          ifid_hold_o,
    input logic          ifid_clear_o,
    input logic          idex_clear_o
);

    always_comb begin
        if (exa_sel_o == 2'b10)
            assert_mem_bypass_src_R1: assert (mem_wen_i && mem_wreg_i != '0 && mem_wreg_i == ex_rs_i);
        if (exa_sel_o == 2'b01)
            assert_wb_bypass_src_R2: assert (wb_wen_i && wb_wreg_i != '0 && wb_wreg_i == ex_rs_i);
        assert_sel_code_legal_R3: assert (exa_sel_o != 2'b11 && exb_sel_o != 2'b11);
        if (ex_load_i && ex_wen_i && ex_wreg_i != '0 && (ex_wreg_i == id_rs_i || ex_wreg_i == id_rt_i))
            assert_load_use_holds_R4: assert (pc_hold_o && idex_clear_o);
        if (bra_sel_o)
            assert_cmp_bypass_src_R7: assert (mem_wen_i && mem_wreg_i == id_rs_i);
        if (ifid_clear_o)
            assert_flush_needs_taken_R8: assert (!pc_hold_o && br_taken_i && id_branch_i);
        assert_hold_bubble_agree_R10: assert (pc_hold_o == idex_clear_o && ifid_hold_o == pc_hold_o);
    end

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.RW(RW)) u_chk (
    .id_rs_i      (id_rs_i),
    .id_rt_i      (id_rt_i),
    .id_branch_i  (id_branch_i),
    .br_taken_i   (br_taken_i),
    .ex_rs_i      (ex_rs_i),
    .ex_wreg_i    (ex_wreg_i),
    .ex_wen_i     (ex_wen_i),
    .ex_load_i    (ex_load_i),
    .mem_wreg_i   (mem_wreg_i),
    .mem_wen_i    (mem_wen_i),
    .wb_wreg_i    (wb_wreg_i),
    .wb_wen_i     (wb_wen_i),
    .exa_sel_o    (exa_sel_o),
    .exb_sel_o    (exb_sel_o),
    .bra_sel_o    (bra_sel_o),
    .pc_hold_o    (pc_hold_o),
    .ifid_hold_o  (ifid_hold_o),
    .ifid_clear_o (ifid_clear_o),
    .idex_clear_o (idex_clear_o)
);

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_wreg, mem_wreg, wb_wreg;
    logic id_branch, br_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [1:0] exa_sel, exb_sel;
    logic bra_sel, brb_sel, pc_hold, ifid_hold, ifid_clear, idex_clear;

    int tests = 0;
    int fails = 0;

    hazard_ctrl #(.RW(RW)) u0 (
        .id_rs_i(id_rs), .id_rt_i(id_rt), .id_branch_i(id_branch), .br_taken_i(br_taken),
        .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_wreg_i(ex_wreg), .ex_wen_i(ex_wen),
        .ex_load_i(ex_load), .mem_wreg_i(mem_wreg), .mem_wen_i(mem_wen),
        .mem_load_i(mem_load), .wb_wreg_i(wb_wreg), .wb_wen_i(wb_wen),
        .exa_sel_o(exa_sel), .exb_sel_o(exb_sel), .bra_sel_o(bra_sel), .brb_sel_o(brb_sel),
        .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .ifid_clear_o(ifid_clear),
        .idex_clear_o(idex_clear)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: expected bypass code for one execute source.
    function automatic int ref_ex(int src);
        if (mem_wen && int'(mem_wreg) != 0 && int'(mem_wreg) == src) return 2;
        if (wb_wen && int'(wb_wreg) != 0 && int'(wb_wreg) == src) return 1;
        return 0;
    endfunction

    function automatic string ex_tag(int e);
        return (e == 2) ? "R1" : (e == 1) ? "R2" : "R3";
    endfunction

    task automatic compare_all();
        int ea, eb, ca, cb, lu, bx, bm, st, fl;
        bit ex_d, mem_d;
        ea = ref_ex(int'(ex_rs));
        eb = ref_ex(int'(ex_rt));
        ca = (mem_wen && int'(mem_wreg) != 0 && mem_wreg == id_rs) ? 1 : 0;
        cb = (mem_wen && int'(mem_wreg) != 0 && mem_wreg == id_rt) ? 1 : 0;
        ex_d  = ex_wen && int'(ex_wreg) != 0 && (ex_wreg == id_rs || ex_wreg == id_rt);
        mem_d = mem_wen && int'(mem_wreg) != 0 && (mem_wreg == id_rs || mem_wreg == id_rt);
        lu = (ex_load && ex_d) ? 1 : 0;
        bx = (id_branch && ex_d) ? 1 : 0;
        bm = (id_branch && mem_load && mem_d) ? 1 : 0;
        st = (lu | bx | bm);
        fl = (id_branch && br_taken && st == 0) ? 1 : 0;
        chk(ex_tag(ea), int'(exa_sel), ea, "exa_sel");
        chk(ex_tag(eb), int'(exb_sel), eb, "exb_sel");
        chk("R7", int'(bra_sel), ca, "bra_sel");
        chk("R7", int'(brb_sel), cb, "brb_sel");
        chk(lu ? "R4" : bx ? "R5" : bm ? "R6" : "R9", int'(pc_hold), st, "pc_hold");
        chk("R10", int'(ifid_hold), st, "ifid_hold");
        chk("R10", int'(idex_clear), st, "idex_clear");
        chk(id_branch ? "R8" : "R9", int'(ifid_clear), fl, "ifid_clear");
    endtask

    task automatic idle();
        id_rs = '0; id_rt = '0; id_branch = 0; br_taken = 0;
        ex_rs = '0; ex_rt = '0; ex_wreg = '0; ex_wen = 0; ex_load = 0;
        mem_wreg = '0; mem_wen = 0; mem_load = 0; wb_wreg = '0; wb_wen = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 50000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // Reset / idle state: everything zero (R3, R9)
        @(negedge clk);
        chk("R3", int'(exa_sel), 0, "idle exa_sel");
        chk("R9", int'(pc_hold), 0, "idle pc_hold");
        @(posedge clk); #1;

        // R1: memory and writeback both match rs -> memory wins
        idle(); ex_rs = 5'd3; mem_wen = 1; mem_wreg = 5'd3; wb_wen = 1; wb_wreg = 5'd3; step();
        // R2: only writeback matches rt
        idle(); ex_rt = 5'd7; wb_wen = 1; wb_wreg = 5'd7; mem_wen = 1; mem_wreg = 5'd6; step();
        // R3: register 0 and cleared enable never bypass
        idle(); mem_wen = 1; wb_wen = 1; step();
        idle(); ex_rs = 5'd4; mem_wreg = 5'd4; wb_wreg = 5'd4; step();
        // R4: load-use on non-branch
        idle(); id_rt = 5'd9; ex_load = 1; ex_wen = 1; ex_wreg = 5'd9; step();
        // R5: ALU producer in execute under a branch
        idle(); id_branch = 1; id_rs = 5'd2; ex_wen = 1; ex_wreg = 5'd2; step();
        // R5 + R8 overlap: taken branch suppressed by stall
        idle(); id_branch = 1; br_taken = 1; id_rt = 5'd2; ex_wen = 1; ex_wreg = 5'd2; step();
        // R6: load in memory stalls branch, taken suppressed
        idle(); id_branch = 1; br_taken = 1; id_rs = 5'd5; mem_wen = 1; mem_load = 1; mem_wreg = 5'd5; step();
        // R6/R7: ALU in memory: no stall, comparator bypass
        idle(); id_branch = 1; id_rs = 5'd5; id_rt = 5'd5; mem_wen = 1; mem_wreg = 5'd5; step();
        // R8: taken branch without hazard flushes
        idle(); id_branch = 1; br_taken = 1; id_rs = 5'd1; id_rt = 5'd2; step();
        // R9: no branch, taken flag and ALU producer ignored
        idle(); br_taken = 1; id_rs = 5'd2; ex_wen = 1; ex_wreg = 5'd2; mem_wen = 1; mem_load = 1; mem_wreg = 5'd3; id_rt = 5'd3; step();
        // Load-use and branch stall together (R4, R5)
        idle(); id_branch = 1; id_rs = 5'd8; ex_load = 1; ex_wen = 1; ex_wreg = 5'd8; step();

        // Random phase, narrow register range to provoke overlaps
        for (int i = 0; i < 3000; i++) begin
            id_rs = RW'($urandom_range(0, 3)); id_rt = RW'($urandom_range(0, 3));
            ex_rs = RW'($urandom_range(0, 3)); ex_rt = RW'($urandom_range(0, 3));
            ex_wreg = RW'($urandom_range(0, 3)); mem_wreg = RW'($urandom_range(0, 3));
            wb_wreg = RW'($urandom_range(0, 3));
            id_branch = 1'($urandom); br_taken = 1'($urandom);
            ex_wen = 1'($urandom); ex_load = 1'($urandom);
            mem_wen = 1'($urandom); mem_load = 1'($urandom); wb_wen = 1'($urandom);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule